// File: doc/BRIEF.md
# Character Attribute and Superimpose Unit

This block sits between the display-memory fetch path and the column drivers of a dot-matrix LCD. For each character time it receives one 16-bit memory word per panel half. The low byte holds the font pixels and the high byte holds either an attribute code or a second graphic byte. The block forms one 8-pixel byte per panel, using either the attribute rules or a plain bitwise OR of the two bytes. It overlays the cursor, optionally doubles every pixel for wide display, and can blank everything when the display is switched off. It then shifts each result out as 4-bit nibbles on an upper-panel bus and a lower-panel bus, with a shift-clock pulse marking every valid nibble.

The mode is a five-bit field. Each bit is the OR of a register bit and a pin with the same meaning. A frame strobe drives an internal blink timer. A character strobe starts the output of one character. The serializer is a two-state machine. **ST_IDLE** waits for the strobe. On a strobe, transition **LOAD** captures the formatted words and moves to **ST_SHIFT**. In **ST_SHIFT**, transition **ADVANCE** moves to the next nibble. On the last nibble, transition **RELOAD** is taken if a new strobe is present and keeps the machine in ST_SHIFT with fresh data. Otherwise transition **DRAIN** returns it to ST_IDLE.

Top module: `lcd_attr_overlay`

## Requirements
- R1: The effective mode bit k is `mode_reg[k] | mode_pin[k]`. Bit 0 enables attributes, bit 1 enables blinking, bit 2 selects wide display, bit 3 selects graphic mode when 1 and character mode when 0, and bit 4 switches the display off when 1.
- R2: In graphic mode, or in character mode with attributes disabled, the pixel byte is the low data byte ORed with the high data byte.
- R3: In character mode with attributes enabled, the high byte is an attribute code. Bit 0 means reverse (pixels inverted), bit 1 means blink, bit 2 means blank to all zeros, and bit 3 means blank to all ones. The priority order is bit 3, then bit 2, then the blink-off rule, then reverse.
- R4: The blink phase is "on" after reset and toggles after every 32 frame strobes. During the off phase, with blinking enabled, a character whose blink bit is set becomes all zeros. With blinking disabled, the blink bit has no effect.
- R5: In character mode, an asserted cursor input inverts the whole pixel byte of that panel. In graphic mode the cursor input has no effect.
- R6: In character mode with wide display set, every pixel is doubled, producing 16 pixels sent as 4 nibbles. In graphic mode the wide bit has no effect and 2 nibbles are sent.
- R7: With the display off, every nibble of the character is zero, while the shift clock still pulses once per nibble.
- R8: A character strobe sampled in ST_IDLE causes the first nibble to appear in the following cycle. The most significant nibble comes first, one nibble per cycle. `shift_clk` is high in exactly those cycles. The two panels use their own word and cursor, in parallel.
- R9: After reset, and whenever `shift_clk` is low, both nibble buses are zero.
- R10: A strobe that arrives while more than one nibble of the current character remains is ignored. A strobe during the last nibble starts the next character in the following cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reg | input | 5 | Mode bits from the register |
| mode_pin | input | 5 | Mode bits from pins, ORed with mode_reg |
| frame_stb | input | 1 | One pulse per frame, drives the blink timer |
| char_stb | input | 1 | One pulse per character, data valid |
| up_word | input | 16 | Upper panel word: high byte attribute or graphic, low byte font |
| dn_word | input | 16 | Lower panel word, same layout |
| up_cursor | input | 1 | Cursor match for the upper panel character |
| dn_cursor | input | 1 | Cursor match for the lower panel character |
| up_nib | output | 4 | Upper panel pixel nibble |
| dn_nib | output | 4 | Lower panel pixel nibble |
| shift_clk | output | 1 | High in every cycle that carries a valid nibble |

## Verification
A wrong nibble counter or state shows up within one character time. It appears as a missing or extra `shift_clk` cycle, or as a nibble in the wrong position, at the first or second cycle after the strobe. A fault in the pixel formatting shows up in the first nibble of the affected character, provided the mode and attribute combination exercises the faulty term; the bench therefore sweeps every mode value against every attribute code and both cursor levels. A wrong blink timer stays invisible until the 32nd frame strobe, so the sweep is repeated in the off phase after exactly 32 strobes.

// File: rtl/lao_pkg.sv
package lao_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_t;

    localparam int MODE_W   = 5;
    localparam int MB_ATTR  = 0;
    localparam int MB_BLINK = 1;
    localparam int MB_WIDE  = 2;
    localparam int MB_GFX   = 3;
    localparam int MB_OFF   = 4;

    localparam int AB_REV   = 0;
    localparam int AB_BLINK = 1;
    localparam int AB_WHITE = 2;
    localparam int AB_BLACK = 3;
endpackage

// File: rtl/lao_blink_timer.sv
module lao_blink_timer #(
    parameter int FRAMES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    output logic phase_on
);
    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            phase_on <= 1'b1;
        end else if (frame_stb) begin
            if (cnt == LAST) begin
                cnt      <= '0;
                phase_on <= ~phase_on;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lao_pixel_fmt.sv
module lao_pixel_fmt
    import lao_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic [2*PIX_W-1:0] word,
    input  logic               cursor,
    input  logic               blink_on,
    output logic [2*PIX_W-1:0] out_word
);
    logic [PIX_W-1:0]   lo, hi, px;
    logic [2*PIX_W-1:0] dbl;
    logic               gfx, use_attr, wide;

    assign lo       = word[PIX_W-1:0];
    assign hi       = word[2*PIX_W-1:PIX_W];
    assign gfx      = mode[MB_GFX];
    assign use_attr = mode[MB_ATTR] & ~gfx;
    assign wide     = mode[MB_WIDE] & ~gfx;

    always_comb begin
        if (use_attr) begin
            if (hi[AB_BLACK])                                   px = '1;
            else if (hi[AB_WHITE])                              px = '0;
            else if (hi[AB_BLINK] && mode[MB_BLINK] && !blink_on) px = '0;
            else if (hi[AB_REV])                                px = ~lo;
            else                                                px = lo;
        end else begin
            px = lo | hi;
        end
        if (!gfx && cursor) px = ~px;
    end

    always_comb begin
        for (int i = 0; i < PIX_W; i++) begin
            dbl[2*i]   = px[i];
            dbl[2*i+1] = px[i];
        end
    end

    always_comb begin
        if (mode[MB_OFF]) out_word = '0;
        else if (wide)    out_word = dbl;
        else              out_word = {px, {PIX_W{1'b0}}};
    end
endmodule

// File: rtl/lao_serializer.sv
module lao_serializer
    import lao_pkg::*;
#(
    parameter int SH_W   = 16,
    parameter int NIB_W  = 4,
    parameter int PANELS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stb,
    input  logic                         wide,
    input  logic [PANELS-1:0][SH_W-1:0]  load_words,
    output logic [PANELS-1:0][NIB_W-1:0] nibs,
    output logic                         shift_clk
);
    localparam int NIB_WIDE = SH_W / NIB_W;
    localparam int NIB_NORM = NIB_WIDE / 2;
    localparam int CNT_W    = $clog2(NIB_WIDE + 1);

    ser_state_t               state, state_nx;
    logic [PANELS-1:0][SH_W-1:0] sh;
    logic [CNT_W-1:0]         left;
    logic                     last, take;

    assign last = (left == CNT_W'(1));
    assign take = stb && (state == ST_IDLE || last);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (stb)  state_nx = ST_SHIFT;
            ST_SHIFT: if (last && !stb) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (take) begin
            sh   <= load_words;
            left <= wide ? CNT_W'(NIB_WIDE) : CNT_W'(NIB_NORM);
        end else if (state == ST_SHIFT) begin
            for (int p = 0; p < PANELS; p++)
                sh[p] <= {sh[p][SH_W-NIB_W-1:0], {NIB_W{1'b0}}};
            left <= left - 1'b1;
        end
    end

    always_comb begin
        shift_clk = (state == ST_SHIFT);
        for (int p = 0; p < PANELS; p++)
            nibs[p] = shift_clk ? sh[p][SH_W-1 -: NIB_W] : '0;
    end
endmodule

// File: rtl/lcd_attr_overlay.sv
module lcd_attr_overlay
    import lao_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int NIB_W  = 4,
    parameter int FRAMES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_reg,
    input  logic [MODE_W-1:0]   mode_pin,
    input  logic                frame_stb,
    input  logic                char_stb,
    input  logic [2*PIX_W-1:0]  up_word,
    input  logic [2*PIX_W-1:0]  dn_word,
    input  logic                up_cursor,
    input  logic                dn_cursor,
    output logic [NIB_W-1:0]    up_nib,
    output logic [NIB_W-1:0]    dn_nib,
    output logic                shift_clk
);
    localparam int PANELS = 2;
    localparam int SH_W   = 2 * PIX_W;

    logic [MODE_W-1:0]           mode;
    logic                        blink_on, wide;
    logic [PANELS-1:0][SH_W-1:0] in_words, fmt_words;
    logic [PANELS-1:0]           cursors;
    logic [PANELS-1:0][NIB_W-1:0] nibs;

    assign mode     = mode_reg | mode_pin;
    assign wide     = mode[MB_WIDE] & ~mode[MB_GFX] & ~mode[MB_OFF];
    assign in_words = {dn_word, up_word};
    assign cursors  = {dn_cursor, up_cursor};

    lao_blink_timer #(.FRAMES(FRAMES)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .phase_on (blink_on)
    );

    for (genvar g = 0; g < PANELS; g++) begin : g_panel
        lao_pixel_fmt #(.PIX_W(PIX_W)) u_fmt (
            .mode    (mode),
            .word    (in_words[g]),
            .cursor  (cursors[g]),
            .blink_on(blink_on),
            .out_word(fmt_words[g])
        );
    end

    lao_serializer #(.SH_W(SH_W), .NIB_W(NIB_W), .PANELS(PANELS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (char_stb),
        .wide      (wide),
        .load_words(fmt_words),
        .nibs      (nibs),
        .shift_clk (shift_clk)
    );

    assign up_nib = nibs[0];
    assign dn_nib = nibs[1];
endmodule

// File: rtl/lao_checker.sv
module lao_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mode_reg,
    input logic [4:0]  mode_pin,
    input logic        char_stb,
    input logic [15:0] up_word,
    input logic [3:0]  up_nib,
    input logic [3:0]  dn_nib,
    input logic        shift_clk
);
    logic [4:0] m;
    logic       gfx_on;
    assign m      = mode_reg | mode_pin;
    assign gfx_on = m[3] && !m[4];

    // R9: nothing on the buses without a shift pulse
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_clk |-> (up_nib == 4'h0 && dn_nib == 4'h0));

    // R7: display off gives zero nibbles
    a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !shift_clk && m[4]) |=> (shift_clk && up_nib == 4'h0 && dn_nib == 4'h0));

    // R2: graphic OR, first nibble
    a_r2_or_first: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !shift_clk && gfx_on) |=>
        (shift_clk && up_nib == ($past(up_word[15:12]) | $past(up_word[7:4]))));

    // R8: second nibble follows on the next cycle
    a_r8_second_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !shift_clk && gfx_on) |=> shift_clk ##1
        (shift_clk && up_nib == ($past(up_word[11:8], 2) | $past(up_word[3:0], 2))));

    // R6: graphic mode never sends more than two nibbles
    a_r6_gfx_two: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !shift_clk && gfx_on) |=> ##2 (!shift_clk || $past(char_stb)));
endmodule

bind lcd_attr_overlay lao_checker u_lao_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_reg (mode_reg),
    .mode_pin (mode_pin),
    .char_stb (char_stb),
    .up_word  (up_word),
    .up_nib   (up_nib),
    .dn_nib   (dn_nib),
    .shift_clk(shift_clk)
);

// File: tb/lcd_attr_overlay_bench.sv
module lcd_attr_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_reg = '0, mode_pin = '0;
    logic        frame_stb = 1'b0, char_stb = 1'b0;
    logic [15:0] up_word = '0, dn_word = '0;
    logic        up_cursor = 1'b0, dn_cursor = 1'b0;
    logic [3:0]  up_nib, dn_nib;
    logic        shift_clk;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_attr_overlay u_lcd_attr_overlay (
        .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .mode_pin(mode_pin),
        .frame_stb(frame_stb), .char_stb(char_stb), .up_word(up_word),
        .dn_word(dn_word), .up_cursor(up_cursor), .dn_cursor(dn_cursor),
        .up_nib(up_nib), .dn_nib(dn_nib), .shift_clk(shift_clk)
    );

    // model: returns {wide, 16-bit nibble stream}
    function automatic logic [16:0] model(input logic [4:0] m, input logic [15:0] w,
                                          input logic cur, input logic ph_on);
        logic [7:0] lo, hi, px;
        logic [15:0] o;
        logic wd;
        lo = w[7:0];
        hi = w[15:8];
        if (m[0] && !m[3]) begin
            if (hi[3])                      px = 8'hFF;
            else if (hi[2])                 px = 8'h00;
            else if (hi[1] && m[1] && !ph_on) px = 8'h00;
            else if (hi[0])                 px = ~lo;
            else                            px = lo;
        end else begin
            px = lo | hi;
        end
        if (!m[3] && cur) px = ~px;
        wd = m[2] && !m[3] && !m[4];
        o = '0;
        if (!m[4]) begin
            if (wd) for (int i = 0; i < 8; i++) begin
                o[2*i] = px[i];
                o[2*i+1] = px[i];
            end
            else o = {px, 8'h00};
        end
        return {wd, o};
    endfunction

    function automatic string tag_of(input logic [4:0] m, input logic [7:0] att,
                                     input logic cur);
        if (m[4]) return "R7";
        if (!m[3] && m[2]) return "R6";
        if (!m[3] && cur) return "R5";
        if (!m[3] && m[0] && att[1]) return "R4";
        if (!m[3] && m[0]) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] mr, input logic [4:0] mp, input logic [15:0] uw,
                        input logic [15:0] dw, input logic uc, input logic dc, input string tag);
        logic [16:0] eu, ed;
        logic [15:0] au, ad;
        int n;
        logic clk_ok;
        eu = model(mr | mp, uw, uc, ((frames / 32) % 2) == 0);
        ed = model(mr | mp, dw, dc, ((frames / 32) % 2) == 0);
        n = eu[16] ? 4 : 2;
        @(negedge clk);
        mode_reg = mr; mode_pin = mp; up_word = uw; dn_word = dw;
        up_cursor = uc; dn_cursor = dc; char_stb = 1'b1;
        @(negedge clk);
        char_stb = 1'b0;
        au = '0; ad = '0; clk_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            au = {au[11:0], up_nib};
            ad = {ad[11:0], dn_nib};
            if (!shift_clk) clk_ok = 1'b0;
            @(negedge clk);
        end
        if (n == 2) begin
            au = {au[7:0], 8'h00};
            ad = {ad[7:0], 8'h00};
        end
        // R8: nibble order, clock pulses, then idle with quiet buses (R9)
        check({"R8/", tag}, {au, ad}, {eu[15:0], ed[15:0]});
        check("R8 shift_clk", {31'd0, clk_ok}, 32'd1);
        check("R9 idle after char", {27'd0, shift_clk, up_nib | dn_nib}, 32'd0);
    endtask

    task automatic pulse_frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
            frames++;
        end
    endtask

    task automatic sweep;
        for (int m = 0; m < 32; m++)
            for (int a = 0; a < 16; a++)
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] mask, mv;
                    logic [7:0] hi, lo;
                    mv = 5'(m);
                    mask = 5'(a * 3) ^ 5'h15; // R1: split each mode between reg and pin
                    hi = {4'(m) ^ 4'h6, 4'(a)};
                    lo = 8'h5A ^ 8'(m * 7 + a);
                    send(mv & mask, mv & ~mask, {hi, lo},
                         {hi[7:4], hi[0], hi[3:1], ~lo}, c[0], ~c[0],
                         tag_of(mv, hi, c[0]));
                end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", {27'd0, shift_clk, up_nib | dn_nib}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", {27'd0, shift_clk, up_nib | dn_nib}, 32'd0);

        // R1: graphic selected by the pin alone, cursor ignored (R5)
        send(5'h01, 5'h08, 16'hF00F, 16'h0330, 1'b1, 1'b1, "R1");
        // R4: blink bit without blink enable, phase on
        send(5'h01, 5'h00, 16'h02C3, 16'h02C3, 1'b0, 1'b0, "R4");

        sweep();               // blink phase on
        pulse_frames(31);
        // R4: one frame before toggle, still on
        send(5'h03, 5'h00, 16'h02C3, 16'h0281, 1'b0, 1'b0, "R4");
        pulse_frames(1);
        // R4: now off, blinking char blanked
        send(5'h01, 5'h02, 16'h02C3, 16'h0281, 1'b0, 1'b0, "R4");
        sweep();               // blink phase off
        pulse_frames(32);
        send(5'h03, 5'h00, 16'h02C3, 16'h0281, 1'b0, 1'b0, "R4");

        // R10: mid-character strobe ignored, last-nibble strobe chains
        begin
            logic [15:0] au;
            @(negedge clk);
            mode_reg = 5'h08; mode_pin = 5'h00;
            up_word = 16'h1234; dn_word = 16'h0000; char_stb = 1'b1;
            @(negedge clk);
            up_word = 16'hFFFF; char_stb = 1'b1;   // ignored
            au = {12'd0, up_nib};
            @(negedge clk);
            up_word = 16'h8008; char_stb = 1'b1;   // accepted on last nibble
            au = {au[11:0], up_nib};
            @(negedge clk);
            char_stb = 1'b0;
            au = {au[11:0], up_nib};
            @(negedge clk);
            au = {au[11:0], up_nib};
            check("R10 chain", {au, 15'd0, shift_clk}, {16'h3688, 16'h0001});
            @(negedge clk);
            check("R10 drain", {31'd0, shift_clk}, 32'd0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end
endmodule